// File: doc/BRIEF.md
# H-Bridge Fixed Off-Time Chopper

This block regulates the current in one motor winding driven by a four-switch H-bridge. Every chopping cycle starts in a drive phase. One diagonal pair of switches is on, and a polarity input selects which pair. An external current comparator reports when the winding current has reached its trip level. The block accepts that report only after a blanking window, so that switching transients are not taken for a trip. It then runs a fixed off period and returns to drive on its own when the period ends.

The off period runs in one of two decay modes. In slow decay, both low-side switches are on. In mixed decay, the bridge first reverses into the opposite diagonal for a fast-decay portion of 5/16 of the off period, then falls back to slow decay for the rest. Recirculating current flows through switched-on transistors rather than body diodes. A zero-current input withdraws those switches so that the load current cannot reverse.

Every change of a half-bridge leg from one switch to the other passes through a dead time with both switches of that leg off. A halt input turns all gates off at once and parks the sequencer. All lengths are given in clock cycles. The defaults suit a 100 MHz clock: 30 us off time, 1 us blanking and 480 ns dead time.

Top module: `hbridge_chopper`

## Requirements
- R1: In reset all four gate enables are low. Each drive phase turns on a diagonal chosen by `dir_i`, sampled when that drive phase begins: 1 turns on `a_src_o` and `b_snk_o`, 0 turns on `b_src_o` and `a_snk_o`. A change of `dir_i` during drive has no effect until the next drive phase.
- R2: The source and sink enables of one leg are never high together. A leg that moves from one of its switches to the other holds both low for exactly DEAD_CYC cycles, and a leg that only turns a switch off does so without delay.
- R3: `trip_i` is ignored during the first BLANK_CYC cycles after any gate enable changes, and while the drive switches are not yet all on. A trip accepted in cycle x makes the gates leave the drive pattern in cycle x+2. With `trip_i` held high, every drive pattern therefore lasts BLANK_CYC+2 cycles.
- R4: In slow decay the active source switch turns off and the sink of the same leg turns on, so both sinks are on.
- R5: With `mixed_i` high at the accepted trip, the off period starts with fast decay, which reverses the bridge into the opposite diagonal. Fast decay lasts FAST = max(1, floor(OFF_CYC*5/16)) cycles of the off period, and slow decay follows for the remaining cycles.
- R6: The off period lasts OFF_CYC cycles of the sequencer. Drive then resumes unconditionally, so the next drive pattern appears OFF_CYC+DEAD_CYC cycles after the gates left drive. This holds whenever a leg has to swap switches at either end of the off period.
- R7: Once `izero_i` is high during an off period, the rectifying switches stay off until the next drive phase: in slow decay the sink that replaced the source, and in fast decay all four. `izero_i` is ignored during drive.
- R8: While `halt_i` is high all four gate enables are low in the same cycle. After release, the block restarts from a drive phase and turns the drive pair on within DEAD_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_i | input | 1 | Forces all gates off and parks the sequencer |
| dir_i | input | 1 | Drive polarity, sampled at each drive start |
| mixed_i | input | 1 | 1 = mixed decay, 0 = slow decay, sampled at trip |
| trip_i | input | 1 | Current comparator output, high = trip level reached |
| izero_i | input | 1 | High when the winding current is at zero |
| a_src_o | output | 1 | Gate enable, leg A high-side switch |
| a_snk_o | output | 1 | Gate enable, leg A low-side switch |
| b_src_o | output | 1 | Gate enable, leg B high-side switch |
| b_snk_o | output | 1 | Gate enable, leg B low-side switch |

## Verification
The bench compares every gate-pattern change, in order, against the patterns the requirements predict. It also compares how many cycles the previous pattern lasted. As a result, a corrupted phase, timer or dead-time counter shows up at the very next pattern change, within one off period at most.

A wrong blanking count or a lost polarity sample changes the length of the drive pattern, or the diagonal that is turned on. This is visible within BLANK_CYC+2 cycles of the affected drive phase. A zero-current latch that clears too early brings a rectifying switch back on inside the same off period.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  // What a half-bridge leg is asked to conduct
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_SRC = 2'd1,
    LEG_SNK = 2'd2
  } leg_e;

  // Chopping sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DRIVE = 2'd1,
    PH_FAST  = 2'd2,
    PH_SLOW  = 2'd3
  } phase_e;

  // Fast-decay share of the off period: 5/16 rounded down, at least one cycle
  function automatic int fast_len(input int off_cyc);
    int f;
    f = (off_cyc * 5) / 16;
    if (f < 1) f = 1;
    return f;
  endfunction

endpackage

// File: rtl/hbc_leg.sv
module hbc_leg
  import hbc_pkg::*;
#(
  parameter int DEAD_CYC = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  leg_e want_i,
  output leg_e now_o,
  output logic src_o,
  output logic snk_o
);

  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYC - 1);

  leg_e          cur_q;
  logic [DW-1:0] dcnt_q;

  // A switch that turns off arms the dead counter; the other switch of the
  // leg may only turn on once the counter has run out.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= LEG_OFF;
      dcnt_q <= '0;
    end else if (halt_i) begin
      cur_q  <= LEG_OFF;
      dcnt_q <= DEAD_LOAD;
    end else if (cur_q != LEG_OFF && cur_q != want_i) begin
      cur_q  <= LEG_OFF;
      dcnt_q <= DEAD_LOAD;
    end else if (cur_q == LEG_OFF && want_i != LEG_OFF && dcnt_q == '0) begin
      cur_q <= want_i;
    end else if (dcnt_q != '0) begin
      dcnt_q <= dcnt_q - 1'b1;
    end
  end

  assign now_o = cur_q;
  assign src_o = (cur_q == LEG_SRC) && !halt_i;
  assign snk_o = (cur_q == LEG_SNK) && !halt_i;

endmodule

// File: rtl/hbc_blank.sv
module hbc_blank #(
  parameter int BLANK_CYC = 100,
  parameter int GW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] gate_i,
  output logic          ok_o
);

  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYC - 1);

  logic [GW-1:0] gate_q;
  logic [BW-1:0] bcnt_q;
  logic          chg;

  assign chg = (gate_i != gate_q);

  // The window restarts on every edge of any gate enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      bcnt_q <= '0;
    end else begin
      gate_q <= gate_i;
      if (chg)                bcnt_q <= BLANK_LOAD;
      else if (bcnt_q != '0)  bcnt_q <= bcnt_q - 1'b1;
    end
  end

  assign ok_o = !chg && (bcnt_q == '0);

endmodule

// File: rtl/hbc_seq.sv
module hbc_seq
  import hbc_pkg::*;
#(
  parameter int OFF_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic dir_i,
  input  logic mixed_i,
  input  logic trip_i,
  input  logic izero_i,
  input  logic accept_ok_i,
  output leg_e want_a_o,
  output leg_e want_b_o
);

  localparam int FAST_CYC = fast_len(OFF_CYC);
  localparam int TW       = $clog2(OFF_CYC + 1);
  localparam logic [TW-1:0] FAST_LAST = TW'(FAST_CYC - 1);
  localparam logic [TW-1:0] OFF_LAST  = TW'(OFF_CYC - 1);

  phase_e        ph_q;
  logic          pol_q;
  logic          zseen_q;
  logic [TW-1:0] tmr_q;

  logic in_off, zon, take;
  leg_e near_leg, far_leg;

  always_comb begin
    in_off = (ph_q == PH_FAST) || (ph_q == PH_SLOW);
    zon    = in_off && (zseen_q || izero_i);
    take   = (ph_q == PH_DRIVE) && trip_i && accept_ok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      pol_q   <= 1'b1;
      zseen_q <= 1'b0;
      tmr_q   <= '0;
    end else if (halt_i) begin
      ph_q    <= PH_IDLE;
      zseen_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          ph_q  <= PH_DRIVE;
          pol_q <= dir_i;
        end
        PH_DRIVE: begin
          if (take) begin
            ph_q    <= mixed_i ? PH_FAST : PH_SLOW;
            tmr_q   <= '0;
            zseen_q <= 1'b0;
          end
        end
        PH_FAST: begin
          tmr_q   <= tmr_q + 1'b1;
          zseen_q <= zseen_q || izero_i;
          if (tmr_q == FAST_LAST) ph_q <= PH_SLOW;
        end
        default: begin
          tmr_q   <= tmr_q + 1'b1;
          zseen_q <= zseen_q || izero_i;
          if (tmr_q == OFF_LAST) begin
            ph_q    <= PH_DRIVE;
            pol_q   <= dir_i;
            zseen_q <= 1'b0;
          end
        end
      endcase
    end
  end

  // "near" is the leg whose source conducts in drive, "far" the other one
  always_comb begin
    case (ph_q)
      PH_DRIVE: begin near_leg = LEG_SRC; far_leg = LEG_SNK; end
      PH_FAST: begin
        near_leg = zon ? LEG_OFF : LEG_SNK;
        far_leg  = zon ? LEG_OFF : LEG_SRC;
      end
      PH_SLOW: begin
        near_leg = zon ? LEG_OFF : LEG_SNK;
        far_leg  = LEG_SNK;
      end
      default: begin near_leg = LEG_OFF; far_leg = LEG_OFF; end
    endcase
    want_a_o = pol_q ? near_leg : far_leg;
    want_b_o = pol_q ? far_leg  : near_leg;
  end

endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import hbc_pkg::*;
#(
  parameter int OFF_CYC   = 3000,
  parameter int BLANK_CYC = 100,
  parameter int DEAD_CYC  = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic dir_i,
  input  logic mixed_i,
  input  logic trip_i,
  input  logic izero_i,
  output logic a_src_o,
  output logic a_snk_o,
  output logic b_src_o,
  output logic b_snk_o
);

  localparam int NLEG = 2;
  localparam int GW   = 2 * NLEG;

  leg_e          want [NLEG];
  leg_e          now  [NLEG];
  logic          src  [NLEG];
  logic          snk  [NLEG];
  logic [GW-1:0] raw_gate;
  logic          blank_ok;
  logic          settled;

  hbc_seq #(.OFF_CYC(OFF_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_i     (halt_i),
    .dir_i      (dir_i),
    .mixed_i    (mixed_i),
    .trip_i     (trip_i),
    .izero_i    (izero_i),
    .accept_ok_i(blank_ok && settled),
    .want_a_o   (want[0]),
    .want_b_o   (want[1])
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hbc_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .halt_i(halt_i),
      .want_i(want[g]),
      .now_o (now[g]),
      .src_o (src[g]),
      .snk_o (snk[g])
    );
  end

  always_comb begin
    settled = 1'b1;
    for (int i = 0; i < NLEG; i++) begin
      raw_gate[GW-1-2*i] = (now[i] == LEG_SRC);
      raw_gate[GW-2-2*i] = (now[i] == LEG_SNK);
      if (now[i] != want[i]) settled = 1'b0;
    end
  end

  hbc_blank #(.BLANK_CYC(BLANK_CYC), .GW(GW)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .gate_i(raw_gate),
    .ok_o  (blank_ok)
  );

  assign a_src_o = src[0];
  assign a_snk_o = snk[0];
  assign b_src_o = src[1];
  assign b_snk_o = snk[1];

endmodule

// File: rtl/hbc_checker.sv
module hbc_checker (
  input logic clk,
  input logic rst_n,
  input logic halt_i,
  input logic a_src,
  input logic a_snk,
  input logic b_src,
  input logic b_snk
);

  // R2: never a shoot-through path inside one leg
  p_leg_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_src && a_snk) && !(b_src && b_snk));

  // R2: the other switch of leg A is not on in the cycle one switch turns off
  p_dead_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(a_src) || $fell(a_snk)) |-> !(a_src || a_snk));

  // R2: same for leg B
  p_dead_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(b_src) || $fell(b_snk)) |-> !(b_src || b_snk));

  // R8: halt silences every gate
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |-> !(a_src || a_snk || b_src || b_snk));

  // R1: the first cycle out of reset has all gates off
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(a_src || a_snk || b_src || b_snk));

endmodule

bind hbridge_chopper hbc_checker u_hbc_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .halt_i(halt_i),
  .a_src (a_src_o),
  .a_snk (a_snk_o),
  .b_src (b_src_o),
  .b_snk (b_snk_o)
);

// File: tb/test_hbridge_chopper.sv
module test_hbridge_chopper;

  localparam int OFF = 32;
  localparam int BLK = 6;
  localparam int DT  = 3;
  localparam int FST = 10;   // floor(32*5/16)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 1'b1;
  logic dir = 1'b1;
  logic mixed = 1'b0;
  logic trip = 1'b0;
  logic izero = 1'b0;
  logic a_src, a_snk, b_src, b_snk;

  always #5 clk = ~clk;

  hbridge_chopper #(.OFF_CYC(OFF), .BLANK_CYC(BLK), .DEAD_CYC(DT)) i_hbridge_chopper (
    .clk(clk), .rst_n(rst_n), .halt_i(halt), .dir_i(dir), .mixed_i(mixed),
    .trip_i(trip), .izero_i(izero),
    .a_src_o(a_src), .a_snk_o(a_snk), .b_src_o(b_src), .b_snk_o(b_snk)
  );

  typedef struct {
    logic [3:0] vec;
    int         dur;
    string      req;
  } exp_t;

  exp_t       q[$];
  int         n_run = 0;
  int         n_fail = 0;
  bit         mon_on = 1'b0;
  logic [3:0] prev_v = 4'b0000;
  int         run_len = 0;

  function automatic logic [3:0] gv();
    return {a_src, a_snk, b_src, b_snk};
  endfunction

  task automatic check(input bit ok, input string r, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic expect_v(input logic [3:0] v, input int d, input string r);
    exp_t e;
    e.vec = v; e.dur = d; e.req = r;
    q.push_back(e);
  endtask

  // Monitor: pops one expected item per gate-pattern change
  always @(negedge clk) begin
    logic [3:0] cv;
    exp_t       e;
    cv = gv();
    if (cv !== prev_v) begin
      if (mon_on) begin
        if (q.size() == 0) begin
          check(1'b0, "R6", "unexpected gate change", int'(cv), int'(prev_v));
        end else begin
          e = q.pop_front();
          check(cv == e.vec, e.req, "gate pattern", int'(cv), int'(e.vec));
          if (e.dur >= 0)
            check(run_len == e.dur, e.req, "previous pattern length", run_len, e.dur);
        end
      end
      prev_v  = cv;
      run_len = 1;
    end else begin
      run_len++;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic start(input bit d, input bit m, input bit t, input bit z);
    dir = d; mixed = m; trip = t; izero = z;
    tick(2);
    mon_on = 1'b1;
    halt = 1'b0;
  endtask

  task automatic finish_seq();
    int n;
    n = 0;
    while (q.size() != 0 && n < 400) begin
      tick(1);
      n++;
    end
    check(q.size() == 0, "R6", "patterns still pending", q.size(), 0);
    mon_on = 1'b0;
    halt = 1'b1;
    #1;
    check(gv() == 4'b0000, "R8", "gates while halted", int'(gv()), 0);
    q.delete();
    tick(DT + 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not end, got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit found;
    tick(3);
    check(gv() == 4'b0000, "R1", "gates in reset", int'(gv()), 0);
    rst_n = 1'b1;
    tick(3);
    check(gv() == 4'b0000, "R1", "gates idle under halt", int'(gv()), 0);

    // Mixed decay, polarity 1, comparator always tripped
    expect_v(4'b1001, -1,           "R1");
    expect_v(4'b0000, BLK + 2,      "R3");
    expect_v(4'b0110, DT,           "R2");
    expect_v(4'b0100, FST - DT,     "R5");
    expect_v(4'b0101, DT,           "R2");
    expect_v(4'b0001, OFF - FST - DT, "R6");
    expect_v(4'b1001, DT,           "R2");
    expect_v(4'b0000, BLK + 2,      "R3");
    start(1'b1, 1'b1, 1'b1, 1'b0);
    finish_seq();

    // Slow decay, polarity 0
    expect_v(4'b0110, -1,       "R1");
    expect_v(4'b0100, BLK + 2,  "R3");
    expect_v(4'b0101, DT,       "R4");
    expect_v(4'b0100, OFF - DT, "R6");
    expect_v(4'b0110, DT,       "R2");
    expect_v(4'b0100, BLK + 2,  "R3");
    start(1'b0, 1'b0, 1'b1, 1'b0);
    finish_seq();

    // Mixed decay, polarity 0
    expect_v(4'b0110, -1,             "R1");
    expect_v(4'b0000, BLK + 2,        "R3");
    expect_v(4'b1001, DT,             "R5");
    expect_v(4'b0001, FST - DT,       "R5");
    expect_v(4'b0101, DT,             "R4");
    expect_v(4'b0100, OFF - FST - DT, "R6");
    expect_v(4'b0110, DT,             "R2");
    start(1'b0, 1'b1, 1'b1, 1'b0);
    finish_seq();

    // Slow decay with zero current: rectifying sink stays off
    expect_v(4'b1001, -1,      "R1");
    expect_v(4'b0001, BLK + 2, "R3");
    expect_v(4'b1001, OFF,     "R7");
    expect_v(4'b0001, BLK + 2, "R7");
    start(1'b1, 1'b0, 1'b1, 1'b1);
    finish_seq();

    // Mixed decay with zero current: fast portion fully off
    expect_v(4'b1001, -1,        "R1");
    expect_v(4'b0000, BLK + 2,   "R3");
    expect_v(4'b0001, FST,       "R7");
    expect_v(4'b1001, OFF - FST, "R7");
    start(1'b1, 1'b1, 1'b1, 1'b1);
    finish_seq();

    // Blanking, zero and polarity changes inside a drive phase
    dir = 1'b1; mixed = 1'b0; trip = 1'b0; izero = 1'b1;
    tick(2);
    halt = 1'b0;
    found = 1'b0;
    for (int i = 0; i < 20 && !found; i++) begin
      tick(1);
      if (gv() == 4'b1001) found = 1'b1;
    end
    check(found, "R1", "drive pair 1 turned on", int'(gv()), 9);
    trip = 1'b1;
    dir = 1'b0;
    tick(BLK);
    trip = 1'b0;
    tick(20);
    check(gv() == 4'b1001, "R3", "trip inside blanking ignored", int'(gv()), 9);
    check(gv() == 4'b1001, "R7", "zero input ignored in drive", int'(gv()), 9);
    check(gv() == 4'b1001, "R1", "polarity change ignored in drive", int'(gv()), 9);
    trip = 1'b1;
    tick(1);
    check(gv() == 4'b1001, "R3", "one cycle after accepted trip", int'(gv()), 9);
    tick(1);
    check(gv() == 4'b0001, "R3", "two cycles after accepted trip", int'(gv()), 1);
    tick(OFF + DT);
    check(gv() == 4'b0110, "R1", "new polarity at next drive", int'(gv()), 6);
    trip = 1'b0;
    halt = 1'b1;
    izero = 1'b0;
    tick(DT + 3);

    // Halt in the middle of fast decay, then restart
    dir = 1'b1; mixed = 1'b1; trip = 1'b1;
    halt = 1'b0;
    found = 1'b0;
    for (int i = 0; i < 100 && !found; i++) begin
      tick(1);
      if (gv() == 4'b0110) found = 1'b1;
    end
    check(found, "R5", "fast decay pattern reached", int'(gv()), 6);
    halt = 1'b1;
    #1;
    check(gv() == 4'b0000, "R8", "halt turns gates off at once", int'(gv()), 0);
    tick(2);
    trip = 1'b0;
    halt = 1'b0;
    found = 1'b0;
    for (int i = 0; i < DT + 1 && !found; i++) begin
      tick(1);
      if (gv() == 4'b1001) found = 1'b1;
    end
    check(found, "R8", "drive resumes after halt", int'(gv()), 9);
    tick(10);
    check(gv() == 4'b1001, "R8", "drive held without trip", int'(gv()), 9);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule